// File: doc/BRIEF.md
# Feature Discovery Responder

This block answers the mandatory feature-discovery exchange on behalf of a device's data-object mailbox. The mailbox hands it each incoming request object one dword at a time. The block keeps the first header dword, which carries the vendor ID and object type. It also keeps the third dword, whose low byte holds the entry index being asked about.

When the request names the discovery pair (vendor 0x0001, type 0x00), the block looks the index up in a parameter table of supported vendor/type pairs. It then returns a three-dword object to the mailbox. A requester walks the table by sending each returned next index back as its next query, and it stops when a next index of zero comes back.

Requests for other pairs are handled in one of two ways. If the pair is in the table, it belongs to another responder, so the request is consumed and nothing is returned. If the pair is not in the table at all, the block pulses an error flag to the mailbox.

Top module: `featDiscResponder`

## Requirements
- R1: After reset, reqReady is 1, while rspValid, rspLast and errFlag are 0.
- R2: A discovery request produces three response dwords.
  - Dword 0 holds the request's vendor ID in bits 15:0, its type in bits 23:16, and zero in bits 31:24.
  - Dword 1 holds the length 3 in bits 17:0.
  - Dword 2 holds the indexed entry's vendor ID in bits 15:0, its type in bits 23:16 and the next index in bits 31:24.
  - rspLast is 1 only with dword 2.
- R3: The index is taken from bits 7:0 of the third request dword. The next index is the index plus one, except that the last table entry reports 0.
- R4: An index at or beyond the table size returns the last entry, with a next index of 0.
- R5: The version field in bits 15:8 of the third request dword has no effect on the response.
- R6: A request whose vendor/type pair is absent from the table produces no response. Instead, errFlag is 1 for exactly one cycle: the second cycle after the final request dword is accepted.
- R7: A request naming a pair that is in the table but is not the discovery pair is consumed with neither a response nor an error, and reqReady returns to 1.
- R8: While rspValid is 1 and rspReady is 0, rspValid, rspData and rspLast hold their values.
- R9: rspValid rises in the second cycle after the final request dword is accepted. reqReady stays 0 from then until the last response dword is taken.
- R10: Request dwords after the third are accepted and ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request dword valid |
| reqReady | output | 1 | Block can take a request dword |
| reqData | input | 32 | Request dword |
| reqLast | input | 1 | Marks the final dword of the request object |
| rspValid | output | 1 | Response dword valid |
| rspReady | input | 1 | Mailbox takes the response dword |
| rspData | output | 32 | Response dword |
| rspLast | output | 1 | Marks the final response dword |
| errFlag | output | 1 | One-cycle pulse for a request naming an unsupported pair |

## Verification
The bench walks the whole default table and checks that the last entry closes the chain with a next index of 0. A design with an off-by-one in the next-index logic would either chain forever or stop one entry early. It queries indices past the end of the table; a design that does not clamp would return an empty entry or wrap back into the table. It varies the version byte alone, sends an over-long request, and stalls the response side. A design that mixed the version into the index, took a later dword as the index, or advanced while stalled would show a wrong payload or a dropped dword. It also sends an unknown pair and a known non-discovery pair, which separates a design that raises the error too broadly from one that answers everything.

// File: rtl/featDiscPkg.sv
package featDiscPkg;
  localparam int WORD_W = 32;
  localparam int ENTRY_W = 24;          // {type[7:0], vid[15:0]}
  localparam logic [15:0] DISC_VID = 16'h0001;
  localparam logic [7:0] DISC_TYPE = 8'h00;
  localparam logic [17:0] RSP_LEN = 18'd3;

  typedef struct packed {
    logic capHdr;      // keep vendor/type of the first request dword
    logic capIdx;      // keep the index of the third request dword
    logic [1:0] txSel; // which response dword to present
  } dpStrobe_t;
endpackage

// File: rtl/featDiscCtrl.sv
module featDiscCtrl
  import featDiscPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic reqLast,
  input  logic rspReady,
  input  logic isDisc,
  input  logic inTable,
  output logic reqReady,
  output logic rspValid,
  output logic rspLast,
  output logic errFlag,
  output dpStrobe_t strobe
);
  typedef enum logic [1:0] {RECV, EVAL, SEND} state_t;

  state_t state;
  logic [1:0] wordCnt;
  logic [1:0] sel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= RECV;
      wordCnt <= '0;
      sel <= '0;
      errFlag <= 1'b0;
    end else begin
      errFlag <= 1'b0;
      case (state)
        RECV: if (reqValid) begin
          if (wordCnt != 2'd3) wordCnt <= wordCnt + 2'd1;
          if (reqLast) begin
            state <= EVAL;
            wordCnt <= '0;
          end
        end
        EVAL: begin
          if (isDisc) begin
            state <= SEND;
            sel <= '0;
          end else begin
            errFlag <= !inTable;
            state <= RECV;
          end
        end
        SEND: if (rspReady) begin
          if (sel == 2'd2) state <= RECV;
          else sel <= sel + 2'd1;
        end
        default: state <= RECV;
      endcase
    end
  end

  always_comb begin
    strobe.capHdr = (state == RECV) && reqValid && (wordCnt == 2'd0);
    strobe.capIdx = (state == RECV) && reqValid && (wordCnt == 2'd2);
    strobe.txSel = sel;
  end

  assign reqReady = (state == RECV);
  assign rspValid = (state == SEND);
  assign rspLast = (state == SEND) && (sel == 2'd2);
endmodule

// File: rtl/featDiscDatapath.sv
module featDiscDatapath
  import featDiscPkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter logic [NUM_ENTRIES*ENTRY_W-1:0] FEAT_TABLE = '0
) (
  input  logic clk,
  input  logic rstN,
  input  logic [WORD_W-1:0] reqData,
  input  dpStrobe_t strobe,
  output logic isDisc,
  output logic inTable,
  output logic [WORD_W-1:0] rspData
);
  localparam logic [7:0] LAST_IDX = 8'(NUM_ENTRIES - 1);

  logic [15:0] hdrVid;
  logic [7:0] hdrType;
  logic [7:0] reqIdx;
  logic [ENTRY_W-1:0] entryArr [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] hitVec;
  logic [7:0] effIdx;
  logic [7:0] nextIdx;
  logic [ENTRY_W-1:0] selEntry;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrVid <= '0;
      hdrType <= '0;
      reqIdx <= '0;
    end else begin
      if (strobe.capHdr) begin
        hdrVid <= reqData[15:0];
        hdrType <= reqData[23:16];
        reqIdx <= '0;
      end
      if (strobe.capIdx) reqIdx <= reqData[7:0];
    end
  end

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gEntry
    assign entryArr[g] = FEAT_TABLE[g*ENTRY_W +: ENTRY_W];
    assign hitVec[g] = (entryArr[g] == {hdrType, hdrVid});
  end

  assign inTable = |hitVec;
  assign isDisc = (hdrVid == DISC_VID) && (hdrType == DISC_TYPE);
  assign effIdx = (reqIdx > LAST_IDX) ? LAST_IDX : reqIdx;
  assign nextIdx = (reqIdx >= LAST_IDX) ? 8'd0 : reqIdx + 8'd1;

  always_comb begin
    selEntry = '0;
    for (int i = 0; i < NUM_ENTRIES; i++)
      if (effIdx == 8'(i)) selEntry = entryArr[i];
  end

  always_comb begin
    case (strobe.txSel)
      2'd0: rspData = {8'h00, hdrType, hdrVid};
      2'd1: rspData = {14'h0, RSP_LEN};
      default: rspData = {nextIdx, selEntry};
    endcase
  end
endmodule

// File: rtl/featDiscResponder.sv
module featDiscResponder
  import featDiscPkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter logic [NUM_ENTRIES*ENTRY_W-1:0] FEAT_TABLE =
    {24'h03_1E98, 24'h02_0001, 24'h01_0001, 24'h00_0001}
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  output logic reqReady,
  input  logic [31:0] reqData,
  input  logic reqLast,
  output logic rspValid,
  input  logic rspReady,
  output logic [31:0] rspData,
  output logic rspLast,
  output logic errFlag
);
  dpStrobe_t strobe;
  logic isDisc;
  logic inTable;

  featDiscCtrl ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLast(reqLast),
    .rspReady(rspReady), .isDisc(isDisc), .inTable(inTable),
    .reqReady(reqReady), .rspValid(rspValid), .rspLast(rspLast),
    .errFlag(errFlag), .strobe(strobe)
  );

  featDiscDatapath #(.NUM_ENTRIES(NUM_ENTRIES), .FEAT_TABLE(FEAT_TABLE)) dp (
    .clk(clk), .rstN(rstN), .reqData(reqData), .strobe(strobe),
    .isDisc(isDisc), .inTable(inTable), .rspData(rspData)
  );
endmodule

// File: rtl/featDiscChecker.sv
module featDiscChecker #(
  parameter int NUM_ENTRIES = 4
) (
  input logic clk,
  input logic rstN,
  input logic reqReady,
  input logic rspValid,
  input logic rspReady,
  input logic [31:0] rspData,
  input logic rspLast,
  input logic errFlag
);
  assert_err_no_rsp_R6: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !rspValid);

  assert_err_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> !errFlag);

  assert_hold_rsp_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid && $stable(rspData) && $stable(rspLast));

  assert_no_req_during_rsp_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

  assert_last_ends_rsp_R2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspReady && rspLast |=> !rspValid);

  assert_last_qualified_R2: assert property (@(posedge clk) disable iff (!rstN)
    rspLast |-> rspValid);

  assert_next_in_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspLast |-> ({1'b0, rspData[31:24]} < 9'(NUM_ENTRIES)));
endmodule

bind featDiscResponder featDiscChecker #(.NUM_ENTRIES(NUM_ENTRIES)) chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rspValid(rspValid),
  .rspReady(rspReady), .rspData(rspData), .rspLast(rspLast), .errFlag(errFlag)
);

// File: tb/featDiscResponder_test.sv
module featDiscResponder_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [31:0] reqData = '0;
  logic reqLast = 1'b0;
  logic rspReady = 1'b1;
  logic reqReady, rspValid, rspLast, errFlag;
  logic [31:0] rspData;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  featDiscResponder uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqData(reqData), .reqLast(reqLast), .rspValid(rspValid),
    .rspReady(rspReady), .rspData(rspData), .rspLast(rspLast), .errFlag(errFlag)
  );

  // {kind[79:72], vid[71:56], type[55:48], idx[47:40], ver[39:32], expPayload[31:0]}
  // kind: 0 response, 1 error, 2 silent
  localparam int NVEC = 10;
  localparam logic [79:0] VEC [NVEC] = '{
    {8'd0, 16'h0001, 8'h00, 8'd0,   8'h00, 32'h0100_0001},
    {8'd0, 16'h0001, 8'h00, 8'd1,   8'h02, 32'h0201_0001},
    {8'd0, 16'h0001, 8'h00, 8'd2,   8'h00, 32'h0302_0001},
    {8'd0, 16'h0001, 8'h00, 8'd3,   8'h02, 32'h0003_1E98},
    {8'd0, 16'h0001, 8'h00, 8'd9,   8'h00, 32'h0003_1E98},
    {8'd0, 16'h0001, 8'h00, 8'd255, 8'h7F, 32'h0003_1E98},
    {8'd0, 16'h0001, 8'h00, 8'd1,   8'hFF, 32'h0201_0001},
    {8'd1, 16'h1234, 8'h05, 8'd0,   8'h00, 32'h0},
    {8'd2, 16'h0001, 8'h01, 8'd0,   8'h00, 32'h0},
    {8'd1, 16'h1E98, 8'h00, 8'd1,   8'h00, 32'h0}
  };
  string vecTag [NVEC] = '{"R2", "R3", "R3", "R3 last", "R4", "R4", "R5",
                           "R6", "R7", "R6"};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Ends at the negedge after the second rising edge following the last dword.
  task automatic sendReq(input logic [15:0] v, input logic [7:0] t,
                         input logic [7:0] idx, input logic [7:0] ver,
                         input int extra);
    for (int w = 0; w < 3 + extra; w++) begin
      @(negedge clk);
      reqValid = 1'b1;
      reqLast = (w == 2 + extra);
      case (w)
        0: reqData = {8'h00, t, v};
        1: reqData = 32'(3 + extra);
        2: reqData = {16'h0, ver, idx};
        default: reqData = 32'hFFFF_FF02;
      endcase
      @(posedge clk);
    end
    @(negedge clk);
    reqValid = 1'b0;
    reqLast = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic takeResp(input logic [15:0] v, input logic [7:0] t,
                          input logic [31:0] expPay, input string tag);
    chk(rspValid && !errFlag, {tag, " R9 rspValid timing"}, {30'h0, rspValid, errFlag}, 32'h2);
    chk(!reqReady, {tag, " R9 reqReady low"}, {31'h0, reqReady}, 32'h0);
    chk(rspData == {8'h00, t, v} && !rspLast, {tag, " R2 hdr1"}, rspData, {8'h00, t, v});
    @(posedge clk); @(negedge clk);
    chk(rspValid && rspData[17:0] == 18'd3 && !rspLast, {tag, " R2 hdr2"}, rspData, 32'd3);
    @(posedge clk); @(negedge clk);
    chk(rspValid && rspLast && rspData == expPay, {tag, " payload"}, rspData, expPay);
    @(posedge clk); @(negedge clk);
    chk(!rspValid && reqReady, {tag, " R9 end"}, {30'h0, rspValid, reqReady}, 32'h1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(reqReady && !rspValid && !rspLast && !errFlag, "R1 reset",
        {28'h0, reqReady, rspValid, rspLast, errFlag}, 32'h8);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !rspValid && !errFlag, "R1 after reset",
        {29'h0, reqReady, rspValid, errFlag}, 32'h4);

    for (int i = 0; i < NVEC; i++) begin
      sendReq(VEC[i][71:56], VEC[i][55:48], VEC[i][47:40], VEC[i][39:32], 0);
      case (VEC[i][79:72])
        8'd0: takeResp(VEC[i][71:56], VEC[i][55:48], VEC[i][31:0], vecTag[i]);
        8'd1: begin
          chk(errFlag && !rspValid, {vecTag[i], " error pulse"},
              {30'h0, errFlag, rspValid}, 32'h2);
          @(posedge clk); @(negedge clk);
          chk(!errFlag && !rspValid && reqReady, {vecTag[i], " single pulse"},
              {29'h0, errFlag, rspValid, reqReady}, 32'h1);
        end
        default: begin
          chk(!errFlag && !rspValid && reqReady, {vecTag[i], " silent"},
              {29'h0, errFlag, rspValid, reqReady}, 32'h1);
          repeat (3) @(posedge clk);
          @(negedge clk);
          chk(!errFlag && !rspValid, {vecTag[i], " still silent"},
              {30'h0, errFlag, rspValid}, 32'h0);
        end
      endcase
    end

    // Walk the chain from entry 0 until next index 0 (R3)
    begin
      logic [7:0] idx = 8'd0;
      int steps = 0;
      do begin
        sendReq(16'h0001, 8'h00, idx, 8'h02, 0);
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        idx = rspData[31:24];
        @(posedge clk); @(negedge clk);
        steps++;
      end while (idx != 8'd0 && steps < 10);
      chk(steps == 4, "R3 chain length", 32'(steps), 32'd4);
    end

    // Backpressure (R8)
    rspReady = 1'b0;
    sendReq(16'h0001, 8'h00, 8'd2, 8'h00, 0);
    chk(rspValid && rspData == 32'h0000_0001, "R8 first word", rspData, 32'h1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rspValid && rspData == 32'h0000_0001 && !rspLast, "R8 held", rspData, 32'h1);
    rspReady = 1'b1;
    takeResp(16'h0001, 8'h00, 32'h0302_0001, "R8");

    // Over-long request: only the third dword carries the index (R10)
    sendReq(16'h0001, 8'h00, 8'd1, 8'h00, 2);
    takeResp(16'h0001, 8'h00, 32'h0201_0001, "R10");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule